// File: doc/BRIEF.md
# Posted-Store Buffer with Read Forwarding

This block sits between a write-through cache and a slow memory port. It takes stores from the CPU into a small ring of address/data slots. An accepted store needs no memory handshake, so the CPU carries on in the same cycle. The slots drain to memory one at a time. The oldest slot goes first, and a slot leaves only when memory acknowledges it. The CPU is held back only when every slot is occupied.

When a cache read miss arrives, all pending slots are searched before the read is allowed out to memory, which closes the read-after-write hazard. If one or more pending slots hold the read address, the data of the most recently stored of them is returned in the same cycle and no memory read is issued. Otherwise the read passes straight through to the memory read port. The search covers the slots held at the start of the cycle. The slot depth must be a power of two, at least 2.

Top module: `wr_post_buffer`

## Requirements
- R1: After reset the buffer is empty: `mem_wr_valid` and `st_stall` are low, and a read finds no match.
- R2: A store presented while `st_stall` is low is taken in that cycle, and from the next cycle `mem_wr_valid` is high.
- R3: `st_stall` is high exactly when all DEPTH slots are occupied; a store presented while it is high is dropped and never reaches the memory write port.
- R4: Slots go out on the memory write port in arrival order. The head address and data stay stable until `mem_wr_ack` is seen with `mem_wr_valid` high, and each such cycle retires exactly one slot.
- R5: In a cycle where a store is taken and a drain completes, the occupancy is unchanged.
- R6: A read whose address matches a pending slot raises `rd_fwd_hit` with that slot's data and leaves `mem_rd_req` low.
- R7: When several pending slots match the read address, the forwarded data is that of the youngest matching slot.
- R8: A read with no matching pending slot raises `mem_rd_req` with `mem_rd_addr` equal to `rd_addr`, and `rd_fwd_hit` stays low.
- R9: The search covers the slots held at the start of the cycle. A store taken in the same cycle as a read is not seen by that read, and a slot that drains in that cycle is still seen.
- R10: While the buffer is full, a store is refused even when a drain completes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| st_valid | input | 1 | Store request from the CPU |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store data |
| st_stall | output | 1 | All slots occupied; the store is not taken |
| rd_valid | input | 1 | Cache read miss request |
| rd_addr | input | ADDR_W | Read word address |
| rd_fwd_hit | output | 1 | Read answered from a pending slot |
| rd_fwd_data | output | DATA_W | Forwarded data |
| mem_rd_req | output | 1 | Read sent on to memory |
| mem_rd_addr | output | ADDR_W | Memory read address |
| mem_wr_valid | output | 1 | Head slot offered to memory |
| mem_wr_addr | output | ADDR_W | Head slot address |
| mem_wr_data | output | DATA_W | Head slot data |
| mem_wr_ack | input | 1 | Memory accepts the head slot |

## Verification
Two pairs of events can fall in the same cycle: a store enqueue with a drain, and a read search with either a same-cycle store or a same-cycle drain of the matching slot. The bench drives these together on purpose, including the case where the buffer is full. A reference queue in the bench decides the outcome, and the following cycles confirm it through the stall timing, the drained sequence and the forwarding result. A long pseudo-random run over a three-bit address space produces repeated addresses and mixed overlaps, and every cycle is compared against the same reference queue.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic [1:0] {
    RING_HOLD = 2'b00,
    RING_POP  = 2'b01,
    RING_PUSH = 2'b10,
    RING_SWAP = 2'b11
  } ring_op_e;
endpackage

// File: rtl/wbuf_ring.sv
module wbuf_ring #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter int PTR_W  = 2,
  parameter int CNT_W  = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push,
  input  logic                           pop,
  input  logic [ADDR_W-1:0]              in_addr,
  input  logic [DATA_W-1:0]              in_data,
  output logic [PTR_W-1:0]               head_ptr,
  output logic [CNT_W-1:0]               occ,
  output logic [DEPTH-1:0][ADDR_W-1:0]   slot_addr,
  output logic [DEPTH-1:0][DATA_W-1:0]   slot_data
);
  import wbuf_pkg::*;

  logic [PTR_W-1:0] head_q, head_d;
  logic [PTR_W-1:0] tail_q, tail_d;
  logic [CNT_W-1:0] occ_q, occ_d;
  ring_op_e         op;

  assign op = ring_op_e'({push, pop});

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    occ_d  = occ_q;
    unique case (op)
      RING_PUSH: begin
        tail_d = tail_q + 1'b1;
        occ_d  = occ_q + 1'b1;
      end
      RING_POP: begin
        head_d = head_q + 1'b1;
        occ_d  = occ_q - 1'b1;
      end
      RING_SWAP: begin
        tail_d = tail_q + 1'b1;
        head_d = head_q + 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else if (op != RING_HOLD) begin
      head_q <= head_d;
      tail_q <= tail_d;
      occ_q  <= occ_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic                wr_en;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   data_q;
    assign wr_en = push && (tail_q == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (wr_en) begin
        addr_q <= in_addr;
        data_q <= in_data;
      end
    end
    assign slot_addr[g] = addr_q;
    assign slot_data[g] = data_q;
  end

  assign head_ptr = head_q;
  assign occ      = occ_q;
endmodule

// File: rtl/wbuf_match.sv
module wbuf_match #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter int PTR_W  = 2,
  parameter int CNT_W  = 3
) (
  input  logic [DEPTH-1:0][ADDR_W-1:0] slot_addr,
  input  logic [DEPTH-1:0][DATA_W-1:0] slot_data,
  input  logic [PTR_W-1:0]             head_ptr,
  input  logic [CNT_W-1:0]             occ,
  input  logic [ADDR_W-1:0]            key,
  output logic                         hit,
  output logic [DATA_W-1:0]            hit_data
);
  logic [DEPTH-1:0][PTR_W-1:0] age;
  logic [DEPTH-1:0]            live_match;

  // age 0 is the oldest slot; a slot is live when its age is below occupancy
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign age[g]        = PTR_W'(g) - head_ptr;
    assign live_match[g] = ({1'b0, age[g]} < occ) && (slot_addr[g] == key);
  end

  logic [PTR_W-1:0] best_age;

  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    best_age = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (live_match[i] && (!hit || age[i] > best_age)) begin
        hit      = 1'b1;
        best_age = age[i];
        hit_data = slot_data[i];
      end
    end
  end
endmodule

// File: rtl/wr_post_buffer.sv
module wr_post_buffer #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  output logic              st_stall,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_fwd_hit,
  output logic [DATA_W-1:0] rd_fwd_data,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  output logic              mem_wr_valid,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic              mem_wr_ack
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;

  logic                         push, pop;
  logic [PTR_W-1:0]             head_ptr;
  logic [CNT_W-1:0]             occ;
  logic [DEPTH-1:0][ADDR_W-1:0] slot_addr;
  logic [DEPTH-1:0][DATA_W-1:0] slot_data;
  logic                         match_hit;
  logic [DATA_W-1:0]            match_data;

  assign st_stall     = (occ == CNT_W'(DEPTH));
  assign mem_wr_valid = (occ != '0);
  assign push         = st_valid && !st_stall;
  assign pop          = mem_wr_valid && mem_wr_ack;

  wbuf_ring #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH),
    .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) ring_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .pop       (pop),
    .in_addr   (st_addr),
    .in_data   (st_data),
    .head_ptr  (head_ptr),
    .occ       (occ),
    .slot_addr (slot_addr),
    .slot_data (slot_data)
  );

  wbuf_match #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH),
    .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) match_i (
    .slot_addr (slot_addr),
    .slot_data (slot_data),
    .head_ptr  (head_ptr),
    .occ       (occ),
    .key       (rd_addr),
    .hit       (match_hit),
    .hit_data  (match_data)
  );

  assign mem_wr_addr = slot_addr[head_ptr];
  assign mem_wr_data = slot_data[head_ptr];

  assign rd_fwd_hit  = rd_valid && match_hit;
  assign rd_fwd_data = rd_fwd_hit ? match_data : '0;
  assign mem_rd_req  = rd_valid && !match_hit;
  assign mem_rd_addr = rd_addr;
endmodule

// File: rtl/wbuf_chk.sv
module wbuf_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_valid,
  input logic              st_stall,
  input logic              rd_valid,
  input logic              rd_fwd_hit,
  input logic              mem_rd_req,
  input logic              mem_wr_valid,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [DATA_W-1:0] mem_wr_data,
  input logic              mem_wr_ack,
  input logic [CNT_W-1:0]  occ
);
  p_empty_no_fwd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_valid |-> !rd_fwd_hit);

  p_taken_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_stall) |=> mem_wr_valid);

  p_stall_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_stall && !(mem_wr_valid && mem_wr_ack)) |=> st_stall);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH));

  p_head_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ack) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  p_swap_keeps_occ_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_stall && mem_wr_valid && mem_wr_ack) |=> $stable(occ));

  p_read_routed_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_fwd_hit != mem_rd_req));

  p_idle_read_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (!rd_fwd_hit && !mem_rd_req));
endmodule

bind wr_post_buffer wbuf_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .st_valid     (st_valid),
  .st_stall     (st_stall),
  .rd_valid     (rd_valid),
  .rd_fwd_hit   (rd_fwd_hit),
  .mem_rd_req   (mem_rd_req),
  .mem_wr_valid (mem_wr_valid),
  .mem_wr_addr  (mem_wr_addr),
  .mem_wr_data  (mem_wr_data),
  .mem_wr_ack   (mem_wr_ack),
  .occ          (occ)
);

// File: tb/wr_post_buffer_tb_top.sv
module wr_post_buffer_tb_top;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int DP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          st_valid = 1'b0;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic          st_stall;
  logic          rd_valid = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          rd_fwd_hit;
  logic [DW-1:0] rd_fwd_data;
  logic          mem_rd_req;
  logic [AW-1:0] mem_rd_addr;
  logic          mem_wr_valid;
  logic [AW-1:0] mem_wr_addr;
  logic [DW-1:0] mem_wr_data;
  logic          mem_wr_ack = 1'b0;

  int total = 0;
  int bad   = 0;

  // reference queue, index 0 is oldest
  logic [AW-1:0] q_addr [DP];
  logic [DW-1:0] q_data [DP];
  int            q_n = 0;

  always #5 clk = ~clk;

  wr_post_buffer #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DP)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_stall(st_stall),
    .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_fwd_hit(rd_fwd_hit), .rd_fwd_data(rd_fwd_data),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_wr_ack(mem_wr_ack)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
    end
  endtask

  // one cycle: drive in the low phase, check combinational outputs, advance model
  task automatic step(input string tag, input bit sv, input logic [AW-1:0] sa,
                      input logic [DW-1:0] sd, input bit ack,
                      input bit rv, input logic [AW-1:0] ra);
    bit            e_hit;
    logic [DW-1:0] e_data;
    bit            accept;
    bit            drain;
    @(negedge clk);
    st_valid = sv; st_addr = sa; st_data = sd;
    mem_wr_ack = ack; rd_valid = rv; rd_addr = ra;
    #1;
    chk(tag, "stall", st_stall, (q_n == DP));
    chk(tag, "wr_valid", mem_wr_valid, (q_n != 0));
    if (q_n != 0) begin
      chk(tag, "wr_addr", mem_wr_addr, q_addr[0]);
      chk(tag, "wr_data", mem_wr_data, q_data[0]);
    end
    e_hit = 1'b0; e_data = '0;
    for (int i = 0; i < q_n; i++)
      if (q_addr[i] == ra) begin e_hit = 1'b1; e_data = q_data[i]; end
    if (rv) begin
      chk(tag, "fwd_hit", rd_fwd_hit, e_hit);
      chk(tag, "mem_rd_req", mem_rd_req, !e_hit);
      if (e_hit) chk(tag, "fwd_data", rd_fwd_data, e_data);
      else       chk(tag, "mem_rd_addr", mem_rd_addr, ra);
    end else begin
      chk(tag, "idle_read", {rd_fwd_hit, mem_rd_req}, 2'b00);
    end
    accept = sv && (q_n < DP);
    drain  = ack && (q_n > 0);
    if (drain) begin
      for (int i = 0; i < DP - 1; i++) begin
        q_addr[i] = q_addr[i+1]; q_data[i] = q_data[i+1];
      end
      q_n--;
    end
    if (accept) begin
      q_addr[q_n] = sa; q_data[q_n] = sd; q_n++;
    end
  endtask

  task automatic idle(input string tag);
    step(tag, 0, '0, '0, 0, 0, '0);
  endtask

  initial begin
    #(10 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset, read finds nothing
    step("R1", 0, '0, '0, 0, 1, 16'h0000);

    // R2 fill, R3 stall and dropped store
    for (int i = 0; i < DP; i++)
      step("R2", 1, 16'h0100 + 16'(i), 32'hA000_0000 + 32'(i), 0, 0, '0);
    step("R3", 1, 16'h0DEAD, 32'hDEAD_DEAD, 0, 1, 16'hDEAD);
    step("R3", 1, 16'h0BEEF, 32'hBEEF_BEEF, 0, 0, '0);
    // R10: full, store with drain in same cycle is refused
    step("R10", 1, 16'h0BAD, 32'hBAD0_0BAD, 1, 1, 16'h0BAD);
    // R4: drain in order with gaps in ack
    for (int i = 0; i < DP + 2; i++)
      step("R4", 0, '0, '0, (i % 2) == 0, 0, '0);
    while (q_n > 0) step("R4", 0, '0, '0, 1, 0, '0);
    idle("R4");

    // R6 R7 R8: duplicates, youngest wins
    step("R7", 1, 16'h0040, 32'h1111_0001, 0, 0, '0);
    step("R7", 1, 16'h0050, 32'h1111_0002, 0, 0, '0);
    step("R7", 1, 16'h0040, 32'h1111_0003, 0, 0, '0);
    step("R7", 0, '0, '0, 0, 1, 16'h0040);
    step("R6", 0, '0, '0, 0, 1, 16'h0050);
    step("R8", 0, '0, '0, 0, 1, 16'h0060);
    // R9: draining slot still seen; oldest 0x40 drains while read 0x40
    step("R9", 0, '0, '0, 1, 1, 16'h0040);
    step("R9", 0, '0, '0, 1, 1, 16'h0050);
    step("R9", 0, '0, '0, 1, 1, 16'h0040);
    step("R9", 0, '0, '0, 0, 1, 16'h0040);
    // R9: store and read of same address in one cycle
    step("R9", 1, 16'h0070, 32'h2222_0001, 0, 1, 16'h0070);
    step("R9", 0, '0, '0, 0, 1, 16'h0070);

    // R5: steady occupancy under simultaneous enqueue and drain
    step("R5", 1, 16'h0071, 32'h2222_0002, 0, 0, '0);
    for (int i = 0; i < 6; i++)
      step("R5", 1, 16'h0080 + 16'(i), 32'h3333_0000 + 32'(i), 1, 0, '0);
    for (int i = 0; i < DP; i++)
      step("R5", 1, 16'h0090 + 16'(i), 32'h4444_0000 + 32'(i), 0, 0, '0);
    while (q_n > 0) step("R5", 0, '0, '0, 1, 0, '0);

    // sweep over a small address space
    lfsr = 16'hACE1;
    for (int c = 0; c < 3000; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step("R4", lfsr[0], 16'(lfsr[3:1]), 32'(c), lfsr[4] & lfsr[5] | lfsr[6],
           lfsr[7], 16'(lfsr[10:8]));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule